// File: doc/BRIEF.md
# Two-Way Time-Transfer Offset and Delay Calculator

This block turns the four event timestamps of a two-way time-transfer exchange into a signed clock offset and a one-way link delay. The master's send time of the synchronisation message is the first event. The slave's receive time of that message is the second. The slave's send time of the delay request is the third, and the master's receive time of that request is the fourth. Each event arrives as a coarse word-clock counter value with a one-cycle strobe.

The block turns every coarse value into bit-clock units (unit intervals, UI) by multiplying it by the parallel word width. The two receive events also get their word-alignment bit-slip count added, and the master receive event gets a measured phase term on top. Once all four corrected values of one exchange are held, the block forms the two directional differences. It then halves their difference and their sum with an arithmetic right shift and raises a one-cycle done strobe. The one-way delays are taken to be equal in both directions.

The block is meant to sit behind the logic that extracts event times from the exchange messages. That logic pulses a strobe whenever it learns a timestamp, and a servo reads the results on the done strobe.

Top module: `ts_offset_calc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `result_done` is 0 and `offset_ui` and `delay_ui` are 0; no timestamp of any set is kept across reset.
- R2: The first and third events are corrected to coarse × WORD_W (WORD_W = 20 by default), with no slip and no phase added.
- R3: The second event is corrected to coarse × WORD_W + `rx_slip_slave`, where the slip is sampled in the same cycle as `ts2_stb`.
- R4: The fourth event is corrected to coarse × WORD_W + `rx_slip_master` + `ts4_phase`, both sampled in the same cycle as `ts4_stb`; all three are unsigned.
- R5: With d21 = t2 − t1 and d43 = t4 − t3 in two's complement of ACC_W bits, `offset_ui` = (d21 − d43) shifted right arithmetically by one (floor of the half, so −3 gives −2).
- R6: `delay_ui` = (d21 + d43) shifted right arithmetically by one.
- R7: If the strobe that completes a set is sampled at clock edge N, then `result_done` is 1 for exactly the cycle after edge N+2, carrying that set's results. `offset_ui` and `delay_ui` hold their values until the next done.
- R8: A `ts1_stb` discards any partly collected set and starts a new one. Strobes of the other events in that same cycle join the new set.
- R9: A strobe of the second, third or fourth event is ignored when no first event is held and `ts1_stb` is low in that cycle.
- R10: A repeated strobe of an event before the set completes replaces its earlier value.
- R11: The second, third and fourth events are accepted in any order, and all four may arrive in one cycle.
- R12: A completed set is consumed. Further strobes of the second, third or fourth events produce no result until a new `ts1_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts1_stb | input | 1 | Master send event strobe |
| ts1_coarse | input | CNT_W | Master send coarse count |
| ts2_stb | input | 1 | Slave receive event strobe |
| ts2_coarse | input | CNT_W | Slave receive coarse count |
| rx_slip_slave | input | SLIP_W | Slave receive bit-slip count |
| ts3_stb | input | 1 | Slave send event strobe |
| ts3_coarse | input | CNT_W | Slave send coarse count |
| ts4_stb | input | 1 | Master receive event strobe |
| ts4_coarse | input | CNT_W | Master receive coarse count |
| rx_slip_master | input | SLIP_W | Master receive bit-slip count |
| ts4_phase | input | PHASE_W | Measured phase term in UI |
| result_done | output | 1 | One-cycle result strobe |
| offset_ui | output | ACC_W | Signed offset in UI |
| delay_ui | output | ACC_W | Signed mean path delay in UI |

## Verification
A result is due three rising edges after the edge at which the bench drives the completing strobe. Those three edges are the collection register, the difference register and the output register. The bench records the posedge count when it drives each strobe, and its reference model queues each completed set with a due count of that value plus three. At every falling edge it compares `result_done` against whether the head of the queue is due. When a result is due it compares both result values, and in every other cycle it checks that the results still equal the last ones delivered. This way, a result that is early or late, a lost one or a spurious one each shows up in the exact cycle where it goes wrong.

// File: rtl/ts_calc_pkg.sv
package ts_calc_pkg;

    localparam int EV_COUNT = 4;

    typedef enum logic [1:0] {
        EV_M_TX = 2'd0,
        EV_S_RX = 2'd1,
        EV_S_TX = 2'd2,
        EV_M_RX = 2'd3
    } ev_e;

    typedef logic [EV_COUNT-1:0] ev_mask_t;

    function automatic logic mask_full(input ev_mask_t m);
        return &m;
    endfunction

endpackage

// File: rtl/ts_correct.sv
module ts_correct #(
    parameter int CNT_W     = 32,
    parameter int SLIP_W    = 5,
    parameter int PHASE_W   = 8,
    parameter int WORD_W    = 20,
    parameter int ACC_W     = 48,
    parameter bit ADD_SLIP  = 1'b0,
    parameter bit ADD_PHASE = 1'b0
) (
    input  logic [CNT_W-1:0]   coarse,
    input  logic [SLIP_W-1:0]  slip,
    input  logic [PHASE_W-1:0] phase,
    output logic [ACC_W-1:0]   value
);
    localparam logic [ACC_W-1:0] WORD_MUL = ACC_W'(WORD_W);

    logic [ACC_W-1:0] scaled;
    logic [ACC_W-1:0] slip_term;
    logic [ACC_W-1:0] phase_term;

    always_comb begin
        scaled = ACC_W'(coarse) * WORD_MUL;
    end

    generate
        if (ADD_SLIP) begin : g_slip
            always_comb slip_term = ACC_W'(slip);
        end else begin : g_noslip
            always_comb slip_term = '0;
        end
        if (ADD_PHASE) begin : g_phase
            always_comb phase_term = ACC_W'(phase);
        end else begin : g_nophase
            always_comb phase_term = '0;
        end
    endgenerate

    always_comb begin
        value = scaled + slip_term + phase_term;
    end
endmodule

// File: rtl/ts_collect.sv
module ts_collect
    import ts_calc_pkg::*;
#(
    parameter int ACC_W = 48
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  ev_mask_t                          stb,
    input  logic [EV_COUNT-1:0][ACC_W-1:0]    corr,
    output logic                              fire,
    output ev_mask_t                          held,
    output logic [EV_COUNT-1:0][ACC_W-1:0]    stamps
);
    typedef struct packed {
        ev_mask_t                           mask;
        logic [EV_COUNT-1:0][ACC_W-1:0]     ts;
    } coll_t;

    coll_t    st_d, st_q;
    ev_mask_t base;
    ev_mask_t accept;

    always_comb begin
        st_d   = st_q;
        fire   = mask_full(st_q.mask);
        base   = fire ? '0 : st_q.mask;
        accept = '0;
        if (stb[EV_M_TX]) begin
            accept = stb;
        end else if (base[EV_M_TX]) begin
            accept = stb & ~ev_mask_t'(1);
        end
        st_d.mask = (stb[EV_M_TX] ? '0 : base) | accept;
        for (int i = 0; i < EV_COUNT; i++) begin
            if (accept[i]) begin
                st_d.ts[i] = corr[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held   = st_q.mask;
    assign stamps = st_q.ts;
endmodule

// File: rtl/ts_solve.sv
module ts_solve
    import ts_calc_pkg::*;
#(
    parameter int ACC_W = 48
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              fire,
    input  logic [EV_COUNT-1:0][ACC_W-1:0]    stamps,
    output logic signed [ACC_W-1:0]           fwd_diff,
    output logic                              done,
    output logic signed [ACC_W-1:0]           offset,
    output logic signed [ACC_W-1:0]           delay
);
    typedef struct packed {
        logic                     vld;
        logic signed [ACC_W-1:0]  d21;
        logic signed [ACC_W-1:0]  d43;
    } diff_t;

    typedef struct packed {
        logic                     done;
        logic signed [ACC_W-1:0]  off;
        logic signed [ACC_W-1:0]  dly;
    } res_t;

    diff_t dif_d, dif_q;
    res_t  res_d, res_q;

    logic signed [ACC_W-1:0] gap;
    logic signed [ACC_W-1:0] span;

    always_comb begin
        dif_d     = dif_q;
        dif_d.vld = fire;
        if (fire) begin
            dif_d.d21 = $signed(stamps[EV_S_RX]) - $signed(stamps[EV_M_TX]);
            dif_d.d43 = $signed(stamps[EV_M_RX]) - $signed(stamps[EV_S_TX]);
        end
    end

    always_comb begin
        res_d      = res_q;
        res_d.done = dif_q.vld;
        gap        = dif_q.d21 - dif_q.d43;
        span       = dif_q.d21 + dif_q.d43;
        if (dif_q.vld) begin
            res_d.off = gap >>> 1;
            res_d.dly = span >>> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dif_q <= '0;
            res_q <= '0;
        end else begin
            dif_q <= dif_d;
            res_q <= res_d;
        end
    end

    assign fwd_diff = dif_q.d21;
    assign done     = res_q.done;
    assign offset   = res_q.off;
    assign delay    = res_q.dly;
endmodule

// File: rtl/ts_offset_calc.sv
module ts_offset_calc
    import ts_calc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SLIP_W  = 5,
    parameter int PHASE_W = 8,
    parameter int WORD_W  = 20,
    parameter int ACC_W   = 48
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ts1_stb,
    input  logic [CNT_W-1:0]          ts1_coarse,
    input  logic                      ts2_stb,
    input  logic [CNT_W-1:0]          ts2_coarse,
    input  logic [SLIP_W-1:0]         rx_slip_slave,
    input  logic                      ts3_stb,
    input  logic [CNT_W-1:0]          ts3_coarse,
    input  logic                      ts4_stb,
    input  logic [CNT_W-1:0]          ts4_coarse,
    input  logic [SLIP_W-1:0]         rx_slip_master,
    input  logic [PHASE_W-1:0]        ts4_phase,
    output logic                      result_done,
    output logic signed [ACC_W-1:0]   offset_ui,
    output logic signed [ACC_W-1:0]   delay_ui
);
    logic [EV_COUNT-1:0][CNT_W-1:0]  coarse_arr;
    logic [EV_COUNT-1:0][SLIP_W-1:0] slip_arr;
    logic [EV_COUNT-1:0][ACC_W-1:0]  corr_arr;
    logic [EV_COUNT-1:0][ACC_W-1:0]  stamps;
    ev_mask_t                        stb_vec;
    ev_mask_t                        held_mask;
    logic                            fire;
    logic signed [ACC_W-1:0]         fwd_diff;

    assign stb_vec    = {ts4_stb, ts3_stb, ts2_stb, ts1_stb};
    assign coarse_arr = {ts4_coarse, ts3_coarse, ts2_coarse, ts1_coarse};
    assign slip_arr   = {rx_slip_master, SLIP_W'(0), rx_slip_slave, SLIP_W'(0)};

    generate
        for (genvar g = 0; g < EV_COUNT; g++) begin : g_corr
            ts_correct #(
                .CNT_W    (CNT_W),
                .SLIP_W   (SLIP_W),
                .PHASE_W  (PHASE_W),
                .WORD_W   (WORD_W),
                .ACC_W    (ACC_W),
                .ADD_SLIP (g == int'(EV_S_RX) || g == int'(EV_M_RX)),
                .ADD_PHASE(g == int'(EV_M_RX))
            ) u_corr (
                .coarse(coarse_arr[g]),
                .slip  (slip_arr[g]),
                .phase (ts4_phase),
                .value (corr_arr[g])
            );
        end
    endgenerate

    ts_collect #(.ACC_W(ACC_W)) u_collect (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb_vec),
        .corr  (corr_arr),
        .fire  (fire),
        .held  (held_mask),
        .stamps(stamps)
    );

    ts_solve #(.ACC_W(ACC_W)) u_solve (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .stamps  (stamps),
        .fwd_diff(fwd_diff),
        .done    (result_done),
        .offset  (offset_ui),
        .delay   (delay_ui)
    );
endmodule

// File: rtl/ts_offset_calc_chk.sv
module ts_offset_calc_chk #(
    parameter int ACC_W = 48
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ts1_stb,
    input logic                      fire,
    input logic [3:0]                held_mask,
    input logic signed [ACC_W-1:0]   fwd_diff,
    input logic                      result_done,
    input logic signed [ACC_W-1:0]   offset_ui,
    input logic signed [ACC_W-1:0]   delay_ui
);
    logic signed [ACC_W-1:0] res_sum;
    assign res_sum = offset_ui + delay_ui;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!result_done && offset_ui == '0 && delay_ui == '0));

    // R7
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_done |-> $past(fire, 2));

    // R7
    fire_yields_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire, 2) |-> result_done);

    // R5
    halves_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_done |-> (res_sum == $past(fwd_diff) || res_sum == $past(fwd_diff) - 1));

    // R8
    new_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts1_stb |=> held_mask[0]);

    // R9
    anchor_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !held_mask[0] |-> held_mask == 4'b0000);

    // R12
    consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ts1_stb) |=> !fire);
endmodule

bind ts_offset_calc ts_offset_calc_chk #(.ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ts1_stb    (ts1_stb),
    .fire       (fire),
    .held_mask  (held_mask),
    .fwd_diff   (fwd_diff),
    .result_done(result_done),
    .offset_ui  (offset_ui),
    .delay_ui   (delay_ui)
);

// File: tb/tb_ts_offset_calc.sv
module tb_ts_offset_calc;
    localparam int CNT_W = 32, SLIP_W = 5, PHASE_W = 8, WORD_W = 20, ACC_W = 48;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ts1_stb = 0, ts2_stb = 0, ts3_stb = 0, ts4_stb = 0;
    logic [CNT_W-1:0] ts1_coarse = '0, ts2_coarse = '0, ts3_coarse = '0, ts4_coarse = '0;
    logic [SLIP_W-1:0] rx_slip_slave = '0, rx_slip_master = '0;
    logic [PHASE_W-1:0] ts4_phase = '0;
    logic result_done;
    logic signed [ACC_W-1:0] offset_ui, delay_ui;

    always #2.5 clk = ~clk;

    ts_offset_calc #(.CNT_W(CNT_W), .SLIP_W(SLIP_W), .PHASE_W(PHASE_W),
                     .WORD_W(WORD_W), .ACC_W(ACC_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .ts1_stb(ts1_stb), .ts1_coarse(ts1_coarse),
        .ts2_stb(ts2_stb), .ts2_coarse(ts2_coarse), .rx_slip_slave(rx_slip_slave),
        .ts3_stb(ts3_stb), .ts3_coarse(ts3_coarse),
        .ts4_stb(ts4_stb), .ts4_coarse(ts4_coarse), .rx_slip_master(rx_slip_master),
        .ts4_phase(ts4_phase),
        .result_done(result_done), .offset_ui(offset_ui), .delay_ui(delay_ui));

    typedef struct {
        longint due;
        longint off;
        longint dly;
        string  tag;
    } exp_t;

    exp_t   q[$];
    int     total = 0, bad = 0;
    longint cyc = 0;
    bit     held[4];
    longint val[4];
    longint last_off = 0, last_dly = 0;
    string  ctx = "R1";
    bit     finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit due_now;
            due_now = (q.size() > 0) && (q[0].due == cyc);
            chk(result_done == due_now, due_now ? q[0].tag : ctx, "done",
                longint'(result_done), longint'(due_now));
            if (due_now) begin
                chk(longint'(offset_ui) == q[0].off, {q[0].tag, "/R5"}, "offset",
                    longint'(offset_ui), q[0].off);
                chk(longint'(delay_ui) == q[0].dly, {q[0].tag, "/R6"}, "delay",
                    longint'(delay_ui), q[0].dly);
                last_off = q[0].off;
                last_dly = q[0].dly;
                void'(q.pop_front());
            end else begin
                chk(longint'(offset_ui) == last_off, "R7", "offset hold",
                    longint'(offset_ui), last_off);
                chk(longint'(delay_ui) == last_dly, "R7", "delay hold",
                    longint'(delay_ui), last_dly);
            end
        end
    end

    // one cycle of stimulus; reference model applies the set-collection rules
    task automatic drive(input bit [3:0] s, input longint c1, input longint c2,
                         input longint c3, input longint c4, input int ss,
                         input int sm, input int ph);
        bit [3:0] acc;
        ts1_stb = s[0]; ts2_stb = s[1]; ts3_stb = s[2]; ts4_stb = s[3];
        ts1_coarse = CNT_W'(c1); ts2_coarse = CNT_W'(c2);
        ts3_coarse = CNT_W'(c3); ts4_coarse = CNT_W'(c4);
        rx_slip_slave = SLIP_W'(ss); rx_slip_master = SLIP_W'(sm);
        ts4_phase = PHASE_W'(ph);
        if (s[0]) begin
            for (int i = 0; i < 4; i++) held[i] = 0;
            acc = s;
        end else if (held[0]) acc = s & 4'b1110;
        else acc = 4'b0000;
        if (acc[0]) val[0] = c1 * WORD_W;
        if (acc[1]) val[1] = c2 * WORD_W + ss;
        if (acc[2]) val[2] = c3 * WORD_W;
        if (acc[3]) val[3] = c4 * WORD_W + sm + ph;
        for (int i = 0; i < 4; i++) if (acc[i]) held[i] = 1;
        if (held[0] && held[1] && held[2] && held[3]) begin
            exp_t e;
            longint a, b;
            a = val[1] - val[0];
            b = val[3] - val[2];
            e.due = cyc + 3;
            e.off = (a - b) >>> 1;
            e.dly = (a + b) >>> 1;
            e.tag = ctx;
            q.push_back(e);
            for (int i = 0; i < 4; i++) held[i] = 0;
        end
        @(posedge clk); #1;
        ts1_stb = 0; ts2_stb = 0; ts3_stb = 0; ts4_stb = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        for (int i = 0; i < 4; i++) held[i] = 0;
        q.delete();
        last_off = 0; last_dly = 0;
        idle(3);
        rst_n = 1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        ctx = "R1";
        do_reset();
        chk(result_done == 0 && offset_ui == 0 && delay_ui == 0, "R1", "reset outputs",
            longint'(offset_ui), 0);
        idle(2);

        // R2 R3 R4: in-order events with slips and phase
        ctx = "R2/R3/R4";
        drive(4'b0001, 100, 0, 0, 0, 0, 0, 0);
        drive(4'b0010, 0, 130, 0, 0, 3, 0, 0);
        drive(4'b0100, 0, 0, 150, 0, 0, 0, 0);
        drive(4'b1000, 0, 0, 0, 175, 0, 5, 7);
        idle(5);

        // R11: reverse order with gaps
        ctx = "R11";
        drive(4'b0001, 5000, 0, 0, 0, 0, 0, 0);
        drive(4'b1000, 0, 0, 0, 5040, 9, 31, 200);
        idle(2);
        drive(4'b0100, 0, 0, 5030, 0, 0, 0, 0);
        drive(4'b0010, 0, 4990, 0, 0, 17, 0, 0);
        idle(5);

        // R5 R6: negative offset, odd sums
        ctx = "R5/R6";
        drive(4'b0001, 20000, 0, 0, 0, 0, 0, 0);
        drive(4'b0110, 0, 19900, 20010, 0, 1, 0, 0);
        drive(4'b1000, 0, 0, 0, 20400, 0, 2, 0);
        idle(5);

        // R8: second t1 discards partial set
        ctx = "R8";
        drive(4'b0001, 700, 0, 0, 0, 0, 0, 0);
        drive(4'b0010, 0, 720, 0, 0, 4, 0, 0);
        drive(4'b0001, 900, 0, 0, 0, 0, 0, 0);
        drive(4'b0100, 0, 0, 950, 0, 0, 0, 0);
        idle(4);
        drive(4'b1000, 0, 0, 0, 980, 0, 6, 1);
        idle(3);
        drive(4'b0010, 0, 910, 0, 0, 2, 0, 0);
        idle(5);

        // R8 R11: full set in one cycle, repeated back to back
        ctx = "R8/R11";
        drive(4'b1111, 40, 60, 80, 95, 1, 2, 3);
        drive(4'b1111, 1000, 900, 1100, 1300, 30, 31, 255);
        drive(4'b1111, 7, 7, 7, 7, 0, 0, 0);
        idle(5);

        // R9: no t1 after reset-consumed state
        ctx = "R9";
        drive(4'b1110, 10, 20, 30, 40, 5, 5, 5);
        drive(4'b0010, 0, 21, 0, 0, 0, 0, 0);
        idle(5);

        // R12: consumed set ignores later strobes
        ctx = "R12";
        drive(4'b1111, 300, 310, 320, 330, 1, 1, 1);
        drive(4'b1110, 0, 400, 401, 402, 3, 3, 3);
        drive(4'b0010, 0, 405, 0, 0, 3, 0, 0);
        idle(5);

        // R10: repeated t2 overwrites
        ctx = "R10";
        drive(4'b0001, 1234, 0, 0, 0, 0, 0, 0);
        drive(4'b0010, 0, 1200, 0, 0, 8, 0, 0);
        drive(4'b0010, 0, 1299, 0, 0, 13, 0, 0);
        drive(4'b1100, 0, 0, 1300, 1320, 0, 4, 9);
        idle(5);

        // R1: reset discards a partial set
        ctx = "R1";
        drive(4'b0001, 50, 0, 0, 0, 0, 0, 0);
        drive(4'b0010, 0, 60, 0, 0, 0, 0, 0);
        do_reset();
        chk(result_done == 0 && offset_ui == 0 && delay_ui == 0, "R1", "post-reset outputs",
            longint'(delay_ui), 0);
        drive(4'b1100, 0, 0, 70, 80, 0, 0, 0);
        idle(5);

        // mixed random traffic, large counters
        ctx = "R5/R6/R8/R9/R10/R11";
        for (int k = 0; k < 400; k++) begin
            bit [3:0] s;
            s = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) != 0) s[0] = 0;
            drive(s, longint'($urandom), longint'($urandom), longint'($urandom),
                  longint'($urandom), int'($urandom_range(0, 31)),
                  int'($urandom_range(0, 31)), int'($urandom_range(0, 255)));
        end
        idle(6);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule